// File: doc/BRIEF.md
# Current-Sense PGA Automatic Gain Controller

This block selects the gain of the programmable amplifier in front of a current-sense ADC. It offers four gain codes (x4, x16, x64, x256). After each conversion it takes the magnitude of the signed input-referred result and moves the gain by at most one code. It steps up when the result is small and steps down when the result nears saturation. Each direction has its own threshold, so the gain does not chatter between two codes.

Every accepted sample is passed out with the gain code that was in force when it was taken. The first conversion after any gain change is dropped, because the amplifier has not settled on that sample. When the channel is enabled, conversions are ignored for a parameterised auto-zero window. The gain then starts at x256. A host lock input can pin the gain to a chosen code. The controller then only relays samples and never steps on its own.

Conversion results are signed, input-referred, 0.6 µV per LSB. The ±150 mV input range fits within the default 20-bit width.

Top module: `pga_agc_top`

## Requirements
- R1: Gain codes are 0=x4, 1=x16, 2=x64, 3=x256. After reset `pga_gain` is 3 and `out_valid` is 0. While the channel is disabled and not locked, `pga_gain` is held at 3, so every enable starts at x256.
- R2: For `SETTLE_CYC` clock cycles after `chan_en` rises, conversions are ignored and produce no output.
- R3: An accepted conversion whose magnitude is strictly below the step-up threshold of the current code raises the gain by one code. The thresholds are 62500 LSB at code 0, 15625 at code 1 and 3907 at code 2. Code 3 never steps up.
- R4: An accepted conversion whose magnitude is strictly above the step-down threshold of the current code lowers the gain by one code. The thresholds are 7163 LSB at code 3, 28647 at code 2 and 114583 at code 1. Code 0 never steps down.
- R5: The magnitude is taken from the two's-complement result, so negative and positive samples behave alike. One conversion changes the gain by at most one code, even at full scale.
- R6: The first conversion after any gain change is discarded. It produces no output and is not used to evaluate the gain.
- R7: An accepted sample appears on `out_valid`/`out_data` one cycle after its `conv_valid`. `out_gain` carries the gain code in force when the sample was taken.
- R8: While `lock_en` is high, `pga_gain` follows `lock_gain` on the next cycle and never steps automatically. A lock that changes the gain counts as a gain change under R6.
- R9: While `chan_en` is low, conversions are ignored and `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Current channel enable |
| lock_en | input | 1 | Hold gain at `lock_gain`, no auto stepping |
| lock_gain | input | 2 | Gain code used while locked |
| conv_valid | input | 1 | Conversion result strobe |
| conv_data | input | W | Signed input-referred result, 0.6 µV/LSB |
| pga_gain | output | 2 | Gain code driven to the amplifier |
| out_valid | output | 1 | Accepted sample strobe |
| out_data | output | W | Accepted sample |
| out_gain | output | 2 | Gain code the sample was taken with |

## Verification
Several properties are checked on every cycle: the one-code step limit, the tag on each sample against the gain of the previous cycle, lock tracking, the x256 start state while idle, and silence while disabled or settling. The comparison rules themselves can only be shown by the bench's scenarios. These are the exact step-up and step-down boundaries, the full-scale samples that may move just one code, the dropped sample after each change, and lock behaviour. The scenarios feed known magnitudes of both signs and compare each outcome with values worked out from the thresholds.

// File: rtl/pga_agc_pkg.sv
package pga_agc_pkg;
    typedef logic [1:0] gain_t;
    localparam gain_t GAIN_X4   = 2'd0;
    localparam gain_t GAIN_X256 = 2'd3;
endpackage

// File: rtl/pga_agc_settle.sv
module pga_agc_settle #(
    parameter int unsigned SETTLE_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chan_en,
    output logic ready
);
    localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    assign ready = (cnt_q == LIMIT);

    always_comb begin
        cnt_d = cnt_q;
        if (!chan_en)
            cnt_d = '0;
        else if (!ready)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pga_agc_cmp.sv
module pga_agc_cmp
    import pga_agc_pkg::*;
#(
    parameter int W          = 20,
    parameter int UP_TH_X4   = 62500,
    parameter int UP_TH_X16  = 15625,
    parameter int UP_TH_X64  = 3907,
    parameter int DN_TH_X16  = 114583,
    parameter int DN_TH_X64  = 28647,
    parameter int DN_TH_X256 = 7163
) (
    input  logic signed [W-1:0] sample,
    input  gain_t               gain,
    output logic                step_up,
    output logic                step_down
);
    localparam int MW = W + 1;

    logic [MW-1:0] ext, mag, up_th, dn_th;

    always_comb begin
        ext = {sample[W-1], sample};
        mag = sample[W-1] ? (~ext + 1'b1) : ext;
        case (gain)
            2'd0:    begin up_th = MW'(UP_TH_X4);  dn_th = '1;                end
            2'd1:    begin up_th = MW'(UP_TH_X16); dn_th = MW'(DN_TH_X16);  end
            2'd2:    begin up_th = MW'(UP_TH_X64); dn_th = MW'(DN_TH_X64);  end
            default: begin up_th = '0;             dn_th = MW'(DN_TH_X256); end
        endcase
        step_up   = (gain != GAIN_X256) && (mag < up_th);
        step_down = (gain != GAIN_X4)   && (mag > dn_th);
    end
endmodule

// File: rtl/pga_agc_top.sv
module pga_agc_top
    import pga_agc_pkg::*;
#(
    parameter int          W          = 20,
    parameter int unsigned SETTLE_CYC = 10000,
    parameter int          UP_TH_X4   = 62500,
    parameter int          UP_TH_X16  = 15625,
    parameter int          UP_TH_X64  = 3907,
    parameter int          DN_TH_X16  = 114583,
    parameter int          DN_TH_X64  = 28647,
    parameter int          DN_TH_X256 = 7163
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chan_en,
    input  logic                lock_en,
    input  logic [1:0]          lock_gain,
    input  logic                conv_valid,
    input  logic signed [W-1:0] conv_data,
    output logic [1:0]          pga_gain,
    output logic                out_valid,
    output logic signed [W-1:0] out_data,
    output logic [1:0]          out_gain
);
    typedef struct packed {
        gain_t               gain;
        logic                discard;
        logic                vld;
        logic signed [W-1:0] data;
        gain_t               tag;
    } agc_t;

    agc_t s_d, s_q;
    logic ready, up, down;

    pga_agc_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .ready(ready)
    );

    pga_agc_cmp #(
        .W(W), .UP_TH_X4(UP_TH_X4), .UP_TH_X16(UP_TH_X16), .UP_TH_X64(UP_TH_X64),
        .DN_TH_X16(DN_TH_X16), .DN_TH_X64(DN_TH_X64), .DN_TH_X256(DN_TH_X256)
    ) u_cmp (
        .sample(conv_data), .gain(s_q.gain), .step_up(up), .step_down(down)
    );

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (!chan_en) begin
            s_d.gain    = lock_en ? lock_gain : GAIN_X256;
            s_d.discard = 1'b0;
        end else begin
            if (ready && conv_valid) begin
                if (s_q.discard) begin
                    s_d.discard = 1'b0;
                end else begin
                    s_d.vld  = 1'b1;
                    s_d.data = conv_data;
                    s_d.tag  = s_q.gain;
                    if (!lock_en && down) begin
                        s_d.gain    = s_q.gain - 2'd1;
                        s_d.discard = 1'b1;
                    end else if (!lock_en && up) begin
                        s_d.gain    = s_q.gain + 2'd1;
                        s_d.discard = 1'b1;
                    end
                end
            end
            if (lock_en && (lock_gain != s_q.gain)) begin
                s_d.gain    = lock_gain;
                s_d.discard = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.gain    <= GAIN_X256;
            s_q.discard <= 1'b0;
            s_q.vld     <= 1'b0;
            s_q.data    <= '0;
            s_q.tag     <= GAIN_X256;
        end else begin
            s_q <= s_d;
        end
    end

    assign pga_gain  = s_q.gain;
    assign out_valid = s_q.vld;
    assign out_data  = s_q.data;
    assign out_gain  = s_q.tag;
endmodule

// File: rtl/pga_agc_chk.sv
module pga_agc_chk #(
    parameter int unsigned SETTLE_CYC = 10000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       chan_en,
    input logic       lock_en,
    input logic [1:0] lock_gain,
    input logic [1:0] pga_gain,
    input logic       out_valid,
    input logic [1:0] out_gain
);
    localparam int unsigned EW  = $clog2(SETTLE_CYC + 2);
    localparam logic [EW-1:0] TOP = EW'(SETTLE_CYC + 1);

    logic [EW-1:0] en_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || !chan_en) en_cnt <= '0;
        else if (en_cnt != TOP) en_cnt <= en_cnt + 1'b1;
    end

    a_r1_idle_at_x256: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(chan_en) && !$past(lock_en)) |-> (pga_gain == 2'd3));

    a_r2_quiet_while_settling: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (en_cnt == TOP));

    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && chan_en && $past(chan_en) && !lock_en && !$past(lock_en)) |->
        (int'(pga_gain) - int'($past(pga_gain)) <= 1 &&
         int'($past(pga_gain)) - int'(pga_gain) <= 1));

    a_r7_tag_matches_gain: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid) |-> (out_gain == $past(pga_gain)));

    a_r8_lock_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lock_en)) |-> (pga_gain == $past(lock_gain)));

    a_r9_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !out_valid);
endmodule

bind pga_agc_top pga_agc_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .lock_en(lock_en),
    .lock_gain(lock_gain), .pga_gain(pga_gain), .out_valid(out_valid),
    .out_gain(out_gain)
);

// File: tb/tb_pga_agc_top.sv
`timescale 1ns/1ps
module tb_pga_agc_top;
    localparam int W = 20;
    localparam int SETTLE = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0, chan_en = 1'b0, lock_en = 1'b0, conv_valid = 1'b0;
    logic [1:0] lock_gain = 2'd0;
    logic signed [W-1:0] conv_data = '0;
    logic [1:0] pga_gain, out_gain;
    logic out_valid;
    logic signed [W-1:0] out_data;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    pga_agc_top #(.W(W), .SETTLE_CYC(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .lock_en(lock_en),
        .lock_gain(lock_gain), .conv_valid(conv_valid), .conv_data(conv_data),
        .pga_gain(pga_gain), .out_valid(out_valid), .out_data(out_data),
        .out_gain(out_gain)
    );

    typedef struct packed {
        logic signed [W-1:0] smp;
        logic                vld;
        logic [1:0]          tag;
        logic [1:0]          nxt;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{20'sd1000,    1'b1, 2'd3, 2'd3},  // R1 starts x256, R3 code 3 never up
        '{20'sd10000,   1'b1, 2'd3, 2'd2},  // R4 above 7163
        '{20'sd500,     1'b0, 2'd0, 2'd2},  // R6 discard
        '{-20'sd20000,  1'b1, 2'd2, 2'd2},  // R5 negative, in band
        '{-20'sd30000,  1'b1, 2'd2, 2'd1},  // R4 R5 negative above 28647
        '{20'sd0,       1'b0, 2'd0, 2'd1},  // R6
        '{20'sd14000,   1'b1, 2'd1, 2'd2},  // R3 below 15625
        '{20'sd100,     1'b0, 2'd0, 2'd2},  // R6
        '{20'sd3000,    1'b1, 2'd2, 2'd3},  // R3 below 3907
        '{20'sd5,       1'b0, 2'd0, 2'd3},  // R6
        '{20'sd249000,  1'b1, 2'd3, 2'd2},  // R5 one step only
        '{20'sd0,       1'b0, 2'd0, 2'd2},
        '{20'sd249000,  1'b1, 2'd2, 2'd1},
        '{20'sd0,       1'b0, 2'd0, 2'd1},
        '{20'sd249000,  1'b1, 2'd1, 2'd0},  // R4 above 114583
        '{20'sd0,       1'b0, 2'd0, 2'd0},
        '{-20'sd250000, 1'b1, 2'd0, 2'd0},  // R4 code 0 never down
        '{20'sd62499,   1'b1, 2'd0, 2'd1},  // R3 just below 62500
        '{20'sd7,       1'b0, 2'd0, 2'd1},
        '{20'sd114583,  1'b1, 2'd1, 2'd1},  // R4 equal is not above
        '{20'sd15625,   1'b1, 2'd1, 2'd1}   // R3 equal is not below
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic signed [W-1:0] v);
        @(negedge clk);
        conv_valid = 1'b1;
        conv_data  = v;
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1", "reset pga_gain", int'(pga_gain), 3);
        chk("R1", "reset out_valid", int'(out_valid), 0);
        rst_n = 1'b1;

        send(20'sd100);
        chk("R9", "output while disabled", int'(out_valid), 0);

        chan_en = 1'b1;
        send(20'sd100);
        chk("R2", "output while settling", int'(out_valid), 0);
        chk("R2", "gain while settling", int'(pga_gain), 3);
        repeat (SETTLE + 4) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            send(VEC[i].smp);
            chk("R6/R7", $sformatf("vec%0d valid", i), int'(out_valid), int'(VEC[i].vld));
            if (VEC[i].vld) begin
                chk("R7", $sformatf("vec%0d tag", i), int'(out_gain), int'(VEC[i].tag));
                chk("R7", $sformatf("vec%0d data", i), int'(out_data), int'(VEC[i].smp));
            end
            chk("R3/R4/R5", $sformatf("vec%0d gain", i), int'(pga_gain), int'(VEC[i].nxt));
        end

        @(negedge clk);
        lock_en = 1'b1;
        lock_gain = 2'd0;
        @(negedge clk);
        chk("R8", "lock gain", int'(pga_gain), 0);
        send(20'sd200);
        chk("R8", "discard after lock change", int'(out_valid), 0);
        send(20'sd200);
        chk("R8", "locked sample valid", int'(out_valid), 1);
        chk("R8", "locked sample tag", int'(out_gain), 0);
        chk("R8", "no step while locked", int'(pga_gain), 0);
        lock_en = 1'b0;
        send(20'sd200);
        chk("R3", "step after unlock", int'(pga_gain), 1);
        chk("R7", "tag after unlock", int'(out_gain), 0);

        chan_en = 1'b0;
        @(negedge clk);
        chk("R1", "idle gain", int'(pga_gain), 3);
        send(20'sd200);
        chk("R9", "ignored when disabled", int'(out_valid), 0);
        chk("R9", "gain unchanged when disabled", int'(pga_gain), 3);

        chan_en = 1'b1;
        repeat (SETTLE - 4) @(negedge clk);
        send(20'sd200);
        chk("R2", "late settling ignored", int'(out_valid), 0);
        repeat (6) @(negedge clk);
        send(-20'sd8000);
        chk("R2", "valid after settling", int'(out_valid), 1);
        chk("R1", "tag at enable", int'(out_gain), 3);
        chk("R4", "step down negative", int'(pga_gain), 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule